// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block controls one general-purpose I/O port of up to eight pins. Software writes three stored registers through a synchronous write strobe: an output data word, a direction word and a drive select word. It can read those registers back, along with the current pad levels. The block does not model the pads. For each pin it produces a tri-state enable and an output value, and it brings out the drive select bit so that the pad can use it as a slew-rate control.

A pin drives its pad when its direction bit is set, or when an external per-pin enable term from programmable logic is high. When both are low, the pin is an input. Each pin can drive push-pull, which is the default, or open-drain. In open-drain mode the pad is pulled low for a 0 and released for a 1. The `ACTIVE_W` parameter builds a narrower port: bits at or above `ACTIVE_W` have no storage, never drive and always read as zero. The asynchronous reset is released through a two-stage synchronizer.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the output data, direction and drive select registers all read 0, every `pad_oe` bit is 0, every `pad_out` bit is 0 and every `drive_sel` bit is 0.
- R2: When a pin's direction bit is 1 and its drive select bit is 0, `pad_oe` is 1 and `pad_out` equals the pin's output data bit, from the first clock after the register write.
- R3: A pin's enable is the OR of its direction bit and its `ext_oe` bit. A change on `ext_oe` reaches `pad_oe` in the same cycle, with no register in between.
- R4: When a pin's direction bit and `ext_oe` bit are both 0, its `pad_oe` is 0.
- R5: When a pin's drive select bit is 1 (open-drain), `pad_out` is 0. `pad_oe` is 1 only when the pin is enabled and its data bit is 0, so the pin is released for a data bit of 1.
- R6: `drive_sel` mirrors the drive select register bit for bit.
- R7: `rdata` is combinational from `addr`: 0 returns the output data register, 1 the direction register, 2 the drive select register and 3 the synchronized pin levels.
- R8: A change on `pin_in` appears on the address-3 readback after exactly two rising clock edges, whatever the pin's direction.
- R9: With `ACTIVE_W` below 8, bits at or above `ACTIVE_W` ignore writes, read as 0 in every register and in the pin readback, and keep `pad_oe`, `pad_out` and `drive_sel` at 0.
- R10: Writing 0x07 to the direction register, with `ext_oe` at 0, enables exactly pins 0 to 2 and leaves the other pins as inputs.
- R11: A write to address 3 changes none of the stored registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select for write and read |
| wdata | input | PORT_W | Write data |
| rdata | output | PORT_W | Read data for `addr` |
| pin_in | input | PORT_W | Pad input levels |
| ext_oe | input | PORT_W | Per-pin output enable from programmable logic |
| pad_oe | output | PORT_W | Per-pin tri-state driver enable |
| pad_out | output | PORT_W | Per-pin driven value |
| drive_sel | output | PORT_W | Per-pin drive select (open-drain or fast slew) |

## Verification
A register write becomes visible on `pad_oe`, `pad_out`, `drive_sel` and `rdata` after the single clock edge that stores it. `ext_oe` and `addr` act in the same cycle, and `pin_in` needs two edges before it can be read back. The bench changes its inputs 1 ns after a rising edge and samples at the following falling edge. Its reference model updates on the same rising edge as the design, so every comparison is taken once all of the design's register stages have settled. The two-edge pin latency is checked at both edges: the old value after the first edge and the new value after the second.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    REG_DOUT = 2'd0,
    REG_DIR  = 2'd1,
    REG_DRV  = 2'd2,
    REG_PIN  = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic stage_d;
  logic out_d;

  always_comb begin
    stage_d = 1'b1;
    out_d   = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= stage_d;
      rst_sync_n <= out_d;
    end
  end
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int PORT_W   = 8,
  parameter int ACTIVE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] dout_q,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] drv_q
);
  localparam logic [PORT_W-1:0] ACT_MASK = {PORT_W{1'b1}} >> (PORT_W - ACTIVE_W);

  logic              dout_en, dir_en, drv_en;
  logic [PORT_W-1:0] dout_d, dir_d, drv_d;

  // write decode and next-state values
  always_comb begin
    dout_en = wr_en && (gpio_reg_e'(addr) == REG_DOUT);
    dir_en  = wr_en && (gpio_reg_e'(addr) == REG_DIR);
    drv_en  = wr_en && (gpio_reg_e'(addr) == REG_DRV);
    dout_d  = dout_en ? wdata : dout_q;
    dir_d   = dir_en  ? wdata : dir_q;
    drv_d   = drv_en  ? wdata : drv_q;
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_bit
    if (i < ACTIVE_W) begin : g_act
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dout_q[i] <= 1'b0;
          dir_q[i]  <= 1'b0;
          drv_q[i]  <= 1'b0;
        end else begin
          dout_q[i] <= dout_d[i];
          dir_q[i]  <= dir_d[i];
          drv_q[i]  <= drv_d[i];
        end
      end
    end else begin : g_idle
      assign dout_q[i] = 1'b0;
      assign dir_q[i]  = 1'b0;
      assign drv_q[i]  = 1'b0;
    end
  end

  // R11
  pin_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3) |=> ($stable(dout_q) && $stable(dir_q) && $stable(drv_q)));

  // R2
  dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1) |=> (dir_q == ($past(wdata) & ACT_MASK)));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int PORT_W   = 8,
  parameter int ACTIVE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_sync
);
  localparam logic [PORT_W-1:0] ACT_MASK = {PORT_W{1'b1}} >> (PORT_W - ACTIVE_W);

  logic [PORT_W-1:0] meta_q;
  logic [PORT_W-1:0] meta_d, sync_d;

  always_comb begin
    meta_d = pin_in;
    sync_d = meta_q;
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_bit
    if (i < ACTIVE_W) begin : g_act
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q[i]   <= 1'b0;
          pin_sync[i] <= 1'b0;
        end else begin
          meta_q[i]   <= meta_d[i];
          pin_sync[i] <= sync_d[i];
        end
      end
    end else begin : g_idle
      assign meta_q[i]   = 1'b0;
      assign pin_sync[i] = 1'b0;
    end
  end

  // checker: counts edges since reset so the two-deep look-back stays valid
  logic [1:0] primed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed_q <= 2'd0;
    else if (primed_q != 2'd3) primed_q <= primed_q + 2'd1;
  end

  // R8
  two_stage_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q >= 2'd2) |-> (pin_sync == ($past(pin_in, 2) & ACT_MASK)));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int PORT_W   = 8,
  parameter int ACTIVE_W = 8
) (
  input  logic [PORT_W-1:0] dout_q,
  input  logic [PORT_W-1:0] dir_q,
  input  logic [PORT_W-1:0] drv_q,
  input  logic [PORT_W-1:0] ext_oe,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] pad_out
);
  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    if (i < ACTIVE_W) begin : g_act
      logic en;
      always_comb begin
        en = dir_q[i] | ext_oe[i];
        if (drv_q[i]) begin
          // open-drain: pull low for 0, release for 1
          pad_oe[i]  = en & ~dout_q[i];
          pad_out[i] = 1'b0;
        end else begin
          pad_oe[i]  = en;
          pad_out[i] = dout_q[i];
        end
      end
    end else begin : g_idle
      assign pad_oe[i]  = 1'b0;
      assign pad_out[i] = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int PORT_W   = 8,
  parameter int ACTIVE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] rdata,
  input  logic [PORT_W-1:0] pin_in,
  input  logic [PORT_W-1:0] ext_oe,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] drive_sel
);
  localparam logic [PORT_W-1:0] ACT_MASK = {PORT_W{1'b1}} >> (PORT_W - ACTIVE_W);

  logic              rst_sync_n;
  logic [PORT_W-1:0] dout_q, dir_q, drv_q, pin_sync;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_cfg_regs #(.PORT_W(PORT_W), .ACTIVE_W(ACTIVE_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .dout_q (dout_q),
    .dir_q  (dir_q),
    .drv_q  (drv_q)
  );

  gpio_in_sync #(.PORT_W(PORT_W), .ACTIVE_W(ACTIVE_W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pin_in   (pin_in),
    .pin_sync (pin_sync)
  );

  gpio_pad_drive #(.PORT_W(PORT_W), .ACTIVE_W(ACTIVE_W)) u_drive (
    .dout_q  (dout_q),
    .dir_q   (dir_q),
    .drv_q   (drv_q),
    .ext_oe  (ext_oe),
    .pad_oe  (pad_oe),
    .pad_out (pad_out)
  );

  assign drive_sel = drv_q;

  always_comb begin
    unique case (gpio_reg_e'(addr))
      REG_DOUT: rdata = dout_q;
      REG_DIR:  rdata = dir_q;
      REG_DRV:  rdata = drv_q;
      default:  rdata = pin_sync;
    endcase
  end

  // R5
  od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pad_oe & drive_sel & pad_out) == '0);

  // R3
  ext_en_drives_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ext_oe & ACT_MASK & ~drive_sel & ~pad_oe) == '0);

  // R9
  upper_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((pad_oe | pad_out | drive_sel | rdata) & ~ACT_MASK) == '0);
endmodule

// File: tb/gpio_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wdata, pin_in, ext_oe;
  logic [7:0] rdata_w [2];
  logic [7:0] oe_w    [2];
  logic [7:0] out_w   [2];
  logic [7:0] drv_w   [2];

  int tests = 0;
  int fails = 0;
  bit chk_on = 1'b0;

  always #2 clk = ~clk;

  gpio_port_ctrl #(.PORT_W(8), .ACTIVE_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata_w[0]), .pin_in(pin_in), .ext_oe(ext_oe),
    .pad_oe(oe_w[0]), .pad_out(out_w[0]), .drive_sel(drv_w[0]));

  gpio_port_ctrl #(.PORT_W(8), .ACTIVE_W(4)) dut_n_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata_w[1]), .pin_in(pin_in), .ext_oe(ext_oe),
    .pad_oe(oe_w[1]), .pad_out(out_w[1]), .drive_sel(drv_w[1]));

  // reference model, one state set per variant
  logic [7:0] msk [2] = '{8'hFF, 8'h0F};
  logic [7:0] m_dout [2], m_dir [2], m_drv [2], m_s1 [2], m_s2 [2];

  always @(posedge clk or negedge rst_n) begin
    for (int v = 0; v < 2; v++) begin
      if (!rst_n) begin
        m_dout[v] <= 8'h00; m_dir[v] <= 8'h00; m_drv[v] <= 8'h00;
        m_s1[v]   <= 8'h00; m_s2[v]  <= 8'h00;
      end else begin
        if (wr_en && addr == 2'd0) m_dout[v] <= wdata & msk[v];
        if (wr_en && addr == 2'd1) m_dir[v]  <= wdata & msk[v];
        if (wr_en && addr == 2'd2) m_drv[v]  <= wdata & msk[v];
        m_s1[v] <= pin_in & msk[v];
        m_s2[v] <= m_s1[v];
      end
    end
  end

  function automatic logic [7:0] exp_oe(int v);
    logic [7:0] en;
    en = (m_dir[v] | ext_oe) & msk[v];
    return en & ~(m_drv[v] & m_dout[v]);
  endfunction

  function automatic logic [7:0] exp_out(int v);
    return m_dout[v] & ~m_drv[v];
  endfunction

  function automatic logic [7:0] exp_rd(int v);
    case (addr)
      2'd0:    return m_dout[v];
      2'd1:    return m_dir[v];
      2'd2:    return m_drv[v];
      default: return m_s2[v];
    endcase
  endfunction

  task automatic cmp(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (chk_on) begin
      cmp("R3 pad_oe",     oe_w[0],    exp_oe(0));
      cmp("R5 pad_out",    out_w[0],   exp_out(0));
      cmp("R6 drive_sel",  drv_w[0],   m_drv[0]);
      cmp("R7 rdata",      rdata_w[0], exp_rd(0));
      cmp("R9 narrow oe",  oe_w[1],    exp_oe(1));
      cmp("R9 narrow out", out_w[1],   exp_out(1));
      cmp("R9 narrow drv", drv_w[1],   m_drv[1]);
      cmp("R9 narrow rd",  rdata_w[1], exp_rd(1));
    end
  end

  task automatic drive_step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    drive_step();
    wr_en = 1'b1; addr = a; wdata = d;
    drive_step();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(int v, logic [1:0] a, logic [7:0] exp, string req);
    drive_step();
    addr = a;
    @(negedge clk);
    cmp(req, rdata_w[v], exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = 2'd0; wdata = 8'h00;
    pin_in = 8'h00; ext_oe = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk_on = 1'b1;

    // R1 reset state
    @(negedge clk);
    cmp("R1 pad_oe", oe_w[0], 8'h00);
    cmp("R1 pad_out", out_w[0], 8'h00);
    cmp("R1 drive_sel", drv_w[0], 8'h00);
    rd_chk(0, 2'd1, 8'h00, "R1 dir");
    rd_chk(0, 2'd0, 8'h00, "R1 dout");

    // R10 and R2: three low pins enabled, push-pull values
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h07);
    @(negedge clk);
    cmp("R10 pad_oe", oe_w[0], 8'h07);
    cmp("R2 pad_out", out_w[0], 8'h05);
    cmp("R4 inputs idle", oe_w[0] & 8'hF8, 8'h00);

    // R3: external enable ORs in, same cycle
    drive_step(); ext_oe = 8'h30;
    @(negedge clk);
    cmp("R3 ext or", oe_w[0], 8'h37);
    drive_step(); ext_oe = 8'h00;
    @(negedge clk);
    cmp("R4 ext removed", oe_w[0], 8'h07);

    // R5/R6: open-drain on pins 0 and 1 (data 1 releases, data 0 pulls low)
    wr(2'd2, 8'h03);
    @(negedge clk);
    cmp("R5 od oe", oe_w[0], 8'h06);
    cmp("R5 od out", out_w[0], 8'h04);
    cmp("R6 drive_sel", drv_w[0], 8'h03);

    // R11: write to pin address ignored
    wr(2'd3, 8'hFF);
    rd_chk(0, 2'd1, 8'h07, "R11 dir kept");
    rd_chk(0, 2'd0, 8'h05, "R11 dout kept");
    rd_chk(0, 2'd2, 8'h03, "R11 drv kept");

    // R8: two-edge latency on pin readback
    drive_step(); pin_in = 8'hA5; addr = 2'd3;
    @(negedge clk);
    @(negedge clk);
    cmp("R8 after one edge", rdata_w[0], 8'h00);
    @(negedge clk);
    cmp("R8 after two edges", rdata_w[0], 8'hA5);
    cmp("R9 narrow pin", rdata_w[1], 8'h05);

    // R9: narrow variant drops upper writes
    wr(2'd1, 8'hFF);
    rd_chk(1, 2'd1, 8'h0F, "R9 narrow dir");
    cmp("R9 narrow oe upper", oe_w[1] & 8'hF0, 8'h00);
    rd_chk(0, 2'd1, 8'hFF, "R7 wide dir");

    // mixed traffic compared every clock
    for (int k = 0; k < 400; k++) begin
      drive_step();
      wr_en  = ($urandom_range(0, 2) == 0);
      addr   = 2'($urandom_range(0, 3));
      wdata  = 8'($urandom);
      pin_in = 8'($urandom);
      ext_oe = 8'($urandom) & 8'($urandom);
    end
    drive_step(); wr_en = 1'b0;
    repeat (3) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule